// File: doc/BRIEF.md
# Seconds-Nanoseconds Time-of-Day Clock with Frequency Trim

This block keeps a 96-bit time of day as three 32-bit fields: whole seconds, nanoseconds within the second, and a fine residue in units of 2^-32 ns. On every running clock cycle it advances the time by a fixed base step of 12.5 ns. A signed trim word adds to or subtracts from that step in 2^-32 ns units, so a host can steer the clock's rate by a little under half a nanosecond per cycle. Carries flow from the residue into nanoseconds. Nanoseconds wrap at one billion into seconds.

A small register port lets a host load each time field, set the trim, and halt or release counting. Reset leaves the clock halted. Software brings it up by loading the three fields and then clearing the halt bit. Reading the residue word freezes a copy of the nanoseconds and seconds taken at that same cycle. Later reads of those two words return the frozen copy, so a three-word read is coherent while the clock keeps running.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds and residue fields are zero, the trim word is zero and the halt bit (control word bit 0) reads 1.
- R2: The register map is: address 0 = residue (live), 1 = nanoseconds snapshot, 2 = seconds snapshot, 3 = trim, 4 = control with bit 0 the halt bit. Trim and control read back the last written value. Any other address reads 0.
- R3: While the halt bit is set and no time field is written, all three time fields keep their value.
- R4: With a zero trim, each running cycle adds exactly 12 ns plus 0x80000000 residue units (12.5 ns). The whole-nanosecond advance of any running cycle is 12 or 13.
- R5: A trim with bit 31 = 0 adds its bits 30:0 to every step in 2^-32 ns units. From residue 0 with trim 0x7FFFFFFF, one step gives residue 0xFFFFFFFF and 12 ns.
- R6: A trim with bit 31 = 1 subtracts its bits 30:0 from every step. A residue borrow is taken from the whole-nanosecond advance, so time never goes backwards. From residue 0 with trim 0xFFFFFFFF, one step gives residue 1 and 12 ns. Trim 0x80000000 behaves as a zero trim.
- R7: Nanoseconds never exceed 999999999. A step that passes that value wraps nanoseconds by one billion and increments seconds.
- R8: Seconds wrap from 0xFFFFFFFF to 0.
- R9: A read of address 0 (with rd_en) captures the live nanoseconds and seconds at that clock edge. Addresses 1 and 2 return that capture until the next residue read.
- R10: A write to a time field loads it at the clock edge, and in that cycle the clock does not advance. A nanoseconds write of one billion or more is dropped with no effect.
- R11: Clearing the halt bit starts counting from the edge after the write. The edge that sets the halt bit still advances the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time step per running cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; at address 0 it captures a snapshot |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |

## Verification
Read data is combinational, so the bench samples `rdata` one time unit after it drives the address at the falling edge, in the same cycle. A write or a snapshot capture takes effect at the next rising edge. The bench therefore checks the snapshot words only on reads issued after the residue read. A halt release written at edge N first advances the clock at edge N+1, and a halt set at edge M still advances at M. The directed single-step cases rely on exactly this: a release followed at once by a set yields one step. The reference model updates at every rising edge from the inputs that were stable since the previous falling edge. It works on one wide integer of 2^-32 ns units rather than on separate fields.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int SEC_W  = 32;
    localparam int NS_W   = 32;
    localparam int RES_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int ACC_W  = RES_W + NS_W;

    localparam logic [ADDR_W-1:0] ADR_RES  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_NS   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TRIM = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd4;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [RES_W-1:0] res;
    } tod_time_t;

    typedef struct packed {
        logic [RES_W-1:0] trim;
        logic             halt;
        logic [NS_W-1:0]  snap_ns;
        logic [SEC_W-1:0] snap_sec;
    } tod_regs_t;

endpackage

// File: rtl/tod_step.sv
module tod_step
    import tod_pkg::*;
#(
    parameter logic [ACC_W-1:0] BASE_STEP = 64'h0000_000C_8000_0000
) (
    input  logic [RES_W-1:0] trim_i,
    input  logic [RES_W-1:0] res_i,
    output logic [NS_W-1:0]  ns_inc_o,
    output logic [RES_W-1:0] res_o
);
    localparam int MAG_W = RES_W - 1;

    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] acc;

    // sign-magnitude trim: top bit selects subtract
    always_comb begin
        mag  = {{(ACC_W-MAG_W){1'b0}}, trim_i[MAG_W-1:0]};
        step = trim_i[RES_W-1] ? (BASE_STEP - mag) : (BASE_STEP + mag);
        acc  = {{NS_W{1'b0}}, res_i} + step;
        res_o    = acc[RES_W-1:0];
        ns_inc_o = acc[ACC_W-1:RES_W];
    end
endmodule

// File: rtl/tod_rollover.sv
module tod_rollover
    import tod_pkg::*;
#(
    parameter logic [NS_W-1:0] NS_PER_SEC = 32'd1000000000
) (
    input  logic [NS_W-1:0]  ns_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [NS_W-1:0]  ns_inc_i,
    output logic [NS_W-1:0]  ns_o,
    output logic [SEC_W-1:0] sec_o,
    output logic             wrap_o
);
    logic [NS_W:0] sum;
    logic [NS_W:0] limit;

    always_comb begin
        limit = {1'b0, NS_PER_SEC};
        sum   = {1'b0, ns_i} + {1'b0, ns_inc_i};
        if (sum >= limit) begin
            wrap_o = 1'b1;
            ns_o   = NS_W'(sum - limit);
        end else begin
            wrap_o = 1'b0;
            ns_o   = sum[NS_W-1:0];
        end
        sec_o = sec_i + SEC_W'(wrap_o);
    end
endmodule

// File: rtl/tod_regif.sv
module tod_regif
    import tod_pkg::*;
#(
    parameter logic [NS_W-1:0] NS_PER_SEC = 32'd1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  tod_time_t         live_i,
    output logic [RES_W-1:0]  trim_o,
    output logic              halt_o,
    output logic              ld_res_o,
    output logic              ld_ns_o,
    output logic              ld_sec_o,
    output logic [DATA_W-1:0] rdata_o
);
    tod_regs_t regs_d, regs_q;
    logic      capture;

    always_comb begin
        capture  = rd_en && (addr == ADR_RES);
        ld_res_o = wr_en && (addr == ADR_RES);
        ld_ns_o  = wr_en && (addr == ADR_NS) && (wdata < NS_PER_SEC);
        ld_sec_o = wr_en && (addr == ADR_SEC);

        regs_d = regs_q;
        if (wr_en && addr == ADR_TRIM) regs_d.trim = wdata;
        if (wr_en && addr == ADR_CTRL) regs_d.halt = wdata[0];
        if (capture) begin
            regs_d.snap_ns  = live_i.ns;
            regs_d.snap_sec = live_i.sec;
        end

        case (addr)
            ADR_RES:  rdata_o = live_i.res;
            ADR_NS:   rdata_o = regs_q.snap_ns;
            ADR_SEC:  rdata_o = regs_q.snap_sec;
            ADR_TRIM: rdata_o = regs_q.trim;
            ADR_CTRL: rdata_o = {{(DATA_W-1){1'b0}}, regs_q.halt};
            default:  rdata_o = '0;
        endcase

        trim_o = regs_q.trim;
        halt_o = regs_q.halt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.trim     <= '0;
            regs_q.halt     <= 1'b1;
            regs_q.snap_ns  <= '0;
            regs_q.snap_sec <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R9: capture takes the live fields of that edge
    assert_snap_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (regs_q.snap_ns == $past(live_i.ns) && regs_q.snap_sec == $past(live_i.sec)));

    // R9: without a residue read the snapshot is frozen
    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(regs_q.snap_ns) && $stable(regs_q.snap_sec)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter logic [ACC_W-1:0] BASE_STEP  = 64'h0000_000C_8000_0000,
    parameter logic [NS_W-1:0]  NS_PER_SEC = 32'd1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [NS_W-1:0] BASE_WHOLE = BASE_STEP[ACC_W-1:RES_W];

    tod_time_t        time_d, time_q;
    logic [RES_W-1:0] trim;
    logic             halt;
    logic             ld_res, ld_ns, ld_sec, ld_any, run;
    logic [NS_W-1:0]  ns_inc, roll_ns;
    logic [RES_W-1:0] step_res;
    logic [SEC_W-1:0] roll_sec;
    logic             wrap;

    tod_regif #(.NS_PER_SEC(NS_PER_SEC)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .live_i   (time_q),
        .trim_o   (trim),
        .halt_o   (halt),
        .ld_res_o (ld_res),
        .ld_ns_o  (ld_ns),
        .ld_sec_o (ld_sec),
        .rdata_o  (rdata)
    );

    tod_step #(.BASE_STEP(BASE_STEP)) u_step (
        .trim_i   (trim),
        .res_i    (time_q.res),
        .ns_inc_o (ns_inc),
        .res_o    (step_res)
    );

    tod_rollover #(.NS_PER_SEC(NS_PER_SEC)) u_roll (
        .ns_i     (time_q.ns),
        .sec_i    (time_q.sec),
        .ns_inc_i (ns_inc),
        .ns_o     (roll_ns),
        .sec_o    (roll_sec),
        .wrap_o   (wrap)
    );

    always_comb begin
        ld_any = ld_res || ld_ns || ld_sec;
        run    = !halt && !ld_any;
        time_d = time_q;
        if (ld_any) begin
            if (ld_res) time_d.res = wdata;
            if (ld_ns)  time_d.ns  = wdata;
            if (ld_sec) time_d.sec = wdata;
        end else if (!halt) begin
            time_d.res = step_res;
            time_d.ns  = roll_ns;
            time_d.sec = roll_sec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else begin
            time_q <= time_d;
        end
    end

    // R7: nanoseconds stay below one second
    assert_ns_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        time_q.ns < NS_PER_SEC);

    // R3: halted and not loaded means every field holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !ld_any) |=> $stable(time_q));

    // R4: whole-ns advance is base or base+1
    assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ns_inc == BASE_WHOLE || ns_inc == BASE_WHOLE + 1'b1));

    // R7: a wrapping step increments seconds
    assert_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ({1'b0, time_q.ns} + {1'b0, ns_inc} >= {1'b0, NS_PER_SEC}))
        |=> (time_q.sec == $past(time_q.sec) + 1'b1));

    // R10: a field load freezes the untouched nanoseconds
    assert_load_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_any && !ld_ns) |=> (time_q.ns == $past(time_q.ns)));

    // R6: time never decreases within a second while running
    assert_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (time_q.ns >= $past(time_q.ns)));
endmodule

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [127:0] BILLION = 128'd1000000000;
    localparam logic [127:0] BASE    = 128'h0C_8000_0000;

    tod_clock dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    // reference model in a single wide count of 2^-32 ns units
    logic [31:0] m_res, m_ns, m_sec, m_trim, m_snap_ns, m_snap_sec;
    logic        m_halt;

    function automatic logic [127:0] model_step(input logic [31:0] trim);
        logic [127:0] st;
        st = trim[31] ? (BASE - 128'(trim[30:0])) : (BASE + 128'(trim[30:0]));
        return st;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = 0; m_ns = 0; m_sec = 0; m_trim = 0; m_halt = 1'b1;
            m_snap_ns = 0; m_snap_sec = 0;
        end else begin
            logic         old_halt;
            logic [127:0] t, whole;
            old_halt = m_halt;
            if (rd_en && addr == 3'd0) begin
                m_snap_ns = m_ns; m_snap_sec = m_sec;
            end
            if (wr_en && addr == 3'd3) m_trim = wdata;
            if (wr_en && addr == 3'd4) m_halt = wdata[0];
            if (wr_en && addr == 3'd0) m_res = wdata;
            else if (wr_en && addr == 3'd2) m_sec = wdata;
            else if (wr_en && addr == 3'd1 && wdata < 32'd1000000000) m_ns = wdata;
            else if (!old_halt) begin
                t = (((128'(m_sec) * BILLION) + 128'(m_ns)) << 32) + 128'(m_res);
                t = t + model_step(m_trim);
                m_res = t[31:0];
                whole = t >> 32;
                m_ns  = 32'(whole % BILLION);
                m_sec = 32'(whole / BILLION);
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_res;
            3'd1: return m_snap_ns;
            3'd2: return m_snap_sec;
            3'd3: return m_trim;
            3'd4: return {31'b0, m_halt};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    endtask

    task automatic rd_hand(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0;
        #1 check(tag, rdata, exp);
    endtask

    task automatic rd_model(input logic [2:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = '0;
        #1 check(tag, rdata, model_read(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    // release then set halt: exactly one step (R11)
    task automatic single_tick();
        wr(3'd4, 32'd0);
        wr(3'd4, 32'd1);
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] n, input logic [31:0] r);
        wr(3'd2, s); wr(3'd1, n); wr(3'd0, r);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_hand(3'd4, 32'd1, "R1 halt after reset");
        rd_hand(3'd3, 32'd0, "R1 trim after reset");
        rd_hand(3'd0, 32'd0, "R1 residue after reset");
        rd_hand(3'd1, 32'd0, "R1 ns after reset");
        rd_hand(3'd2, 32'd0, "R1 sec after reset");

        // R4 / R11 zero trim single steps
        single_tick();
        rd_hand(3'd0, 32'h8000_0000, "R4 residue after one step");
        rd_hand(3'd1, 32'd12, "R4 ns after one step");
        single_tick();
        rd_hand(3'd0, 32'd0, "R4 residue after two steps");
        rd_hand(3'd1, 32'd25, "R4 ns after two steps");

        // R3 halted holds
        idle(20);
        rd_hand(3'd0, 32'd0, "R3 residue held");
        rd_hand(3'd1, 32'd25, "R3 ns held");

        // R5 max positive trim
        load(32'd0, 32'd0, 32'd0);
        wr(3'd3, 32'h7FFF_FFFF);
        single_tick();
        rd_hand(3'd0, 32'hFFFF_FFFF, "R5 residue max positive trim");
        rd_hand(3'd1, 32'd12, "R5 ns max positive trim");

        // R6 max negative trim, negative zero, borrow
        load(32'd0, 32'd0, 32'd0);
        wr(3'd3, 32'hFFFF_FFFF);
        single_tick();
        rd_hand(3'd0, 32'd1, "R6 residue max negative trim");
        rd_hand(3'd1, 32'd12, "R6 ns max negative trim");
        load(32'd0, 32'd0, 32'd0);
        wr(3'd3, 32'h8000_0000);
        single_tick();
        rd_hand(3'd0, 32'h8000_0000, "R6 negative zero trim");
        load(32'd0, 32'd0, 32'h10);
        wr(3'd3, 32'h8000_0020);
        single_tick();
        rd_hand(3'd0, 32'h7FFF_FFF0, "R6 residue borrow");
        rd_hand(3'd1, 32'd12, "R6 ns after borrow");

        // R7 rollover
        wr(3'd3, 32'd0);
        load(32'd41, 32'd999999990, 32'd0);
        single_tick();
        rd_hand(3'd0, 32'h8000_0000, "R7 residue at rollover");
        rd_hand(3'd1, 32'd2, "R7 ns wrapped");
        rd_hand(3'd2, 32'd42, "R7 seconds incremented");

        // R8 seconds wrap
        load(32'hFFFF_FFFF, 32'd999999990, 32'd0);
        single_tick();
        rd_hand(3'd0, 32'h8000_0000, "R8 residue at wrap");
        rd_hand(3'd1, 32'd2, "R8 ns at wrap");
        rd_hand(3'd2, 32'd0, "R8 seconds wrapped");

        // R10 load while running freezes that cycle
        load(32'd7, 32'd100, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd0, 32'd5);
        wr(3'd4, 32'd1);
        rd_hand(3'd0, 32'h8000_0005, "R10 residue after load then step");
        rd_hand(3'd1, 32'd112, "R10 ns one step only");
        rd_hand(3'd2, 32'd7, "R10 seconds held");
        wr(3'd1, 32'd1000000000);
        rd_hand(3'd0, 32'h8000_0005, "R10 residue after dropped write");
        rd_hand(3'd1, 32'd112, "R10 oversize ns write dropped");

        // R9 snapshot frozen until next residue read
        rd_hand(3'd0, 32'h8000_0005, "R9 capture read");
        single_tick();
        rd_hand(3'd1, 32'd112, "R9 ns from old snapshot");
        rd_hand(3'd2, 32'd7, "R9 sec from old snapshot");
        rd_hand(3'd0, 32'h0000_0005, "R9 live residue");
        rd_hand(3'd1, 32'd125, "R9 ns from new snapshot");

        // R2 register map readback
        wr(3'd3, 32'h8000_0005);
        rd_hand(3'd3, 32'h8000_0005, "R2 trim readback");
        rd_hand(3'd4, 32'd1, "R2 control readback");
        rd_hand(3'd7, 32'd0, "R2 unmapped address");

        // random mix checked against the model
        for (int it = 0; it < 200; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: wr(3'd3, {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 31'($urandom)});
                1: begin
                    wr(3'd4, 32'd0);
                    idle(int'($urandom_range(1, 40)));
                    wr(3'd4, 32'd1);
                end
                2: wr(3'd1, 32'd999999800 + 32'($urandom_range(0, 199)) + ($urandom_range(0, 3) == 0 ? 32'd400 : 32'd0));
                3: wr(3'd2, $urandom);
                4: wr(3'd0, $urandom);
                default: begin
                    wr(3'd4, 32'd0);
                    rd_model(3'd0, "R9 live capture while running");
                    idle(int'($urandom_range(0, 5)));
                    rd_model(3'd1, "R9 ns snapshot while running");
                    rd_model(3'd2, "R9 sec snapshot while running");
                    wr(3'd4, 32'd1);
                end
            endcase
            rd_model(3'd0, "R4 random residue");
            rd_model(3'd1, "R7 random ns");
            rd_model(3'd2, "R8 random sec");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule